// File: doc/BRIEF.md
# Flag Offset Programming Port

This block holds the two distances that a FIFO's flag logic compares against its fill level: one measured up from empty (the almost-empty offset) and one measured down from full (the almost-full offset). Each is `log2(DEPTH)` bits wide. Both come up at a default of 127 after reset. Software changes them through the FIFO's own data pins, without any address. An active-low load input switches the port from normal FIFO traffic to offset access. While load is low, each enabled write-clock edge stores the low bits of the write data into one offset. The target alternates: the empty offset first, then the full offset, then the empty offset again. Each enabled read-clock edge returns one offset on the readback output, in the same alternating order.

The write-side selector and the read-side selector are separate. Each is clocked in its own domain and steps only on its own enabled edges. While load is low, the block tells the FIFO core not to perform memory writes or reads. While load is high, enables pass through to the core as normal traffic. Computing the flags from the offsets is the job of a neighbouring block.

Top module: `flag_ofs_port`

## Requirements
- R1: While `rst_ni` is low, and after it is released, both offsets read 127, `prog_rdata_o` is 0, and both selectors point at the empty offset.
- R2: On a `wr_clk_i` rising edge with `load_ni`=0 and `wr_en_ni`=0, the selected offset takes `wr_data_i[OFS_W-1:0]`. Bits above `OFS_W-1` are ignored.
- R3: Successive programming writes target the empty offset, then the full offset, then the empty offset, and keep alternating in that order.
- R4: A `wr_clk_i` edge with `wr_en_ni`=1 changes neither offset and does not step the write selector, whatever the value of `load_ni`.
- R5: With `load_ni`=1 and `wr_en_ni`=0, `mem_wr_en_o` is 1. The edge leaves both offsets and the write selector unchanged.
- R6: Raising `load_ni` after one or two programming writes keeps the selector position. The next programming write continues the alternation from where it stopped.
- R7: On an `rd_clk_i` rising edge with `load_ni`=0 and `rd_en_ni`=0, `prog_rdata_o` takes the offset selected by the read selector, empty first and then alternating. The read selector steps on each such edge.
- R8: `mem_wr_en_o` is 1 only when `load_ni`=1 and `wr_en_ni`=0. `mem_rd_en_o` is 1 only when `load_ni`=1 and `rd_en_ni`=0. `prog_rdata_o` holds its value on every read edge that is not a readback.
- R9: Bits of `prog_rdata_o` above `OFS_W-1` always read 0.
- R10: Programming writes do not move the read selector, and readbacks do not move the write selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write-side clock |
| rd_clk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_ni | input | 1 | Low selects offset access, high selects normal traffic |
| wr_en_ni | input | 1 | Active-low write enable |
| rd_en_ni | input | 1 | Active-low read enable |
| wr_data_i | input | DATA_W | Write data; low OFS_W bits feed the offsets |
| prog_rdata_o | output | DATA_W | Offset readback, zero-extended |
| ae_ofs_o | output | OFS_W | Almost-empty offset to the flag logic |
| af_ofs_o | output | OFS_W | Almost-full offset to the flag logic |
| mem_wr_en_o | output | 1 | Memory write permitted to the FIFO core |
| mem_rd_en_o | output | 1 | Memory read permitted to the FIFO core |

## Verification
The bench programs three writes in a row to see whether the target wraps back to the empty offset. A selector that saturates or skips would leave the full offset overwritten or untouched. It raises load after an odd number of writes and then resumes. A design that clears the selector on load would put the next value in the wrong offset. Reads are interleaved with writes to catch selectors that are shared between domains, because shared selectors would return the offsets in the wrong order. Write data with the upper bits set exposes an offset that keeps those bits or a readback that does not zero them. Disabled edges and normal-traffic edges are checked to confirm that neither offset nor readback moves, and that the memory enables are suppressed only while load is low.

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;
  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } ofs_sel_e;

  function automatic ofs_sel_e sel_next(ofs_sel_e s);
    return (s == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  endfunction
endpackage

// File: rtl/ofs_sel_step.sv
module ofs_sel_step
  import ofs_prog_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     step_i,
  output ofs_sel_e sel_o
);
  ofs_sel_e sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= SEL_EMPTY;
    else if (step_i) sel_q <= sel_next(sel_q);
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/ofs_bank.sv
module ofs_bank
  import ofs_prog_pkg::*;
#(
  parameter int OFS_W       = 14,
  parameter int DEFAULT_OFS = 127
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  ofs_sel_e         sel_i,
  input  logic [OFS_W-1:0] wdata_i,
  output logic [OFS_W-1:0] ae_o,
  output logic [OFS_W-1:0] af_o
);
  localparam int                NUM_OFS = 2;
  localparam logic [OFS_W-1:0]  OFS_RST = OFS_W'(DEFAULT_OFS);

  logic [OFS_W-1:0] ofs_q [NUM_OFS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_OFS; i++) ofs_q[i] <= OFS_RST;
    end else begin
      for (int i = 0; i < NUM_OFS; i++)
        if (we_i && (sel_i == ofs_sel_e'(i))) ofs_q[i] <= wdata_i;
    end
  end

  assign ae_o = ofs_q[SEL_EMPTY];
  assign af_o = ofs_q[SEL_FULL];
endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
  import ofs_prog_pkg::*;
#(
  parameter int OFS_W  = 14,
  parameter int DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  ofs_sel_e          sel_i,
  input  logic [OFS_W-1:0]  ae_i,
  input  logic [OFS_W-1:0]  af_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [OFS_W-1:0]  pick;
  logic [DATA_W-1:0] rdata_q;

  always_comb pick = (sel_i == SEL_FULL) ? af_i : ae_i;

  // offsets are quasi-static while load is low; sampled directly
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= DATA_W'(pick);
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/flag_ofs_port.sv
module flag_ofs_port
  import ofs_prog_pkg::*;
#(
  parameter int DEPTH       = 16384,
  parameter int DATA_W      = 18,
  parameter int DEFAULT_OFS = 127,
  localparam int OFS_W      = $clog2(DEPTH)
) (
  input  logic              wr_clk_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic              load_ni,
  input  logic              wr_en_ni,
  input  logic              rd_en_ni,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] prog_rdata_o,
  output logic [OFS_W-1:0]  ae_ofs_o,
  output logic [OFS_W-1:0]  af_ofs_o,
  output logic              mem_wr_en_o,
  output logic              mem_rd_en_o
);
  logic     prog_wr, prog_rd;
  ofs_sel_e wr_sel, rd_sel;

  always_comb begin
    prog_wr     = !load_ni && !wr_en_ni;
    prog_rd     = !load_ni && !rd_en_ni;
    mem_wr_en_o =  load_ni && !wr_en_ni;
    mem_rd_en_o =  load_ni && !rd_en_ni;
  end

  ofs_sel_step u_wr_sel (
    .clk_i (wr_clk_i),
    .rst_ni(rst_ni),
    .step_i(prog_wr),
    .sel_o (wr_sel)
  );

  ofs_sel_step u_rd_sel (
    .clk_i (rd_clk_i),
    .rst_ni(rst_ni),
    .step_i(prog_rd),
    .sel_o (rd_sel)
  );

  ofs_bank #(
    .OFS_W      (OFS_W),
    .DEFAULT_OFS(DEFAULT_OFS)
  ) u_bank (
    .clk_i  (wr_clk_i),
    .rst_ni (rst_ni),
    .we_i   (prog_wr),
    .sel_i  (wr_sel),
    .wdata_i(wr_data_i[OFS_W-1:0]),
    .ae_o   (ae_ofs_o),
    .af_o   (af_ofs_o)
  );

  ofs_readback #(
    .OFS_W (OFS_W),
    .DATA_W(DATA_W)
  ) u_rdbk (
    .clk_i  (rd_clk_i),
    .rst_ni (rst_ni),
    .re_i   (prog_rd),
    .sel_i  (rd_sel),
    .ae_i   (ae_ofs_o),
    .af_i   (af_ofs_o),
    .rdata_o(prog_rdata_o)
  );
endmodule

// File: rtl/flag_ofs_port_chk.sv
module flag_ofs_port_chk #(
  parameter int DEPTH  = 16384,
  parameter int DATA_W = 18,
  localparam int OFS_W = $clog2(DEPTH)
) (
  input logic              wr_clk_i,
  input logic              rd_clk_i,
  input logic              rst_ni,
  input logic              load_ni,
  input logic              wr_en_ni,
  input logic              rd_en_ni,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] prog_rdata_o,
  input logic [OFS_W-1:0]  ae_ofs_o,
  input logic [OFS_W-1:0]  af_ofs_o,
  input logic              mem_wr_en_o,
  input logic              mem_rd_en_o
);
  // R2
  prog_write_lands_chk: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (!load_ni && !wr_en_ni) |=>
      (ae_ofs_o == $past(wr_data_i[OFS_W-1:0]) || af_ofs_o == $past(wr_data_i[OFS_W-1:0])));

  // R4
  idle_write_keeps_chk: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    wr_en_ni |=> ($stable(ae_ofs_o) && $stable(af_ofs_o)));

  // R5
  normal_write_keeps_chk: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (load_ni && !wr_en_ni) |=> ($stable(ae_ofs_o) && $stable(af_ofs_o)));

  // R8
  mem_wr_gated_chk: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    !load_ni |-> !mem_wr_en_o);

  // R8
  mem_rd_gated_chk: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    !load_ni |-> !mem_rd_en_o);

  // R8
  rdata_hold_chk: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (load_ni || rd_en_ni) |=> $stable(prog_rdata_o));

  // R9
  generate
    if (DATA_W > OFS_W) begin : g_hi
      rdata_hi_zero_chk: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
        prog_rdata_o[DATA_W-1:OFS_W] == '0);
    end
  endgenerate
endmodule

bind flag_ofs_port flag_ofs_port_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .wr_clk_i    (wr_clk_i),
  .rd_clk_i    (rd_clk_i),
  .rst_ni      (rst_ni),
  .load_ni     (load_ni),
  .wr_en_ni    (wr_en_ni),
  .rd_en_ni    (rd_en_ni),
  .wr_data_i   (wr_data_i),
  .prog_rdata_o(prog_rdata_o),
  .ae_ofs_o    (ae_ofs_o),
  .af_ofs_o    (af_ofs_o),
  .mem_wr_en_o (mem_wr_en_o),
  .mem_rd_en_o (mem_rd_en_o)
);

// File: tb/flag_ofs_port_test.sv
`timescale 1ns/1ps
module flag_ofs_port_test;
  localparam int DEPTH  = 16384;
  localparam int DATA_W = 18;
  localparam int OFS_W  = $clog2(DEPTH);
  localparam int DEF    = 127;

  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic load_n = 1, wr_en_n = 1, rd_en_n = 1;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rdata;
  logic [OFS_W-1:0]  ae, af;
  logic mem_we, mem_re;

  always #2 wr_clk = ~wr_clk;
  always #3 rd_clk = ~rd_clk;

  flag_ofs_port #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEFAULT_OFS(DEF)) uut (
    .wr_clk_i(wr_clk), .rd_clk_i(rd_clk), .rst_ni(rst_n), .load_ni(load_n),
    .wr_en_ni(wr_en_n), .rd_en_ni(rd_en_n), .wr_data_i(wr_data),
    .prog_rdata_o(rdata), .ae_ofs_o(ae), .af_ofs_o(af),
    .mem_wr_en_o(mem_we), .mem_rd_en_o(mem_re)
  );

  int n_cmp = 0, n_err = 0;
  logic [OFS_W-1:0] m_ae, m_af;
  bit wsel, rsel;
  logic [DATA_W-1:0] exp_q[$];
  logic [DATA_W-1:0] ex;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_ofs(input string req);
    chk(ae == m_ae, req, 32'(ae), 32'(m_ae));
    chk(af == m_af, req, 32'(af), 32'(m_af));
  endtask

  task automatic do_reset();
    rst_n = 0;
    m_ae = OFS_W'(DEF); m_af = OFS_W'(DEF); wsel = 0; rsel = 0;
    repeat (3) @(negedge wr_clk);
    rst_n = 1;
    repeat (2) @(negedge wr_clk);
  endtask

  task automatic set_load(input logic v);
    @(negedge wr_clk); load_n = v;
    repeat (2) @(negedge rd_clk);
  endtask

  task automatic do_write(input logic [DATA_W-1:0] d, input logic en_n);
    @(negedge wr_clk);
    wr_data = d; wr_en_n = en_n;
    #1;
    chk(mem_we == (load_n && !en_n), "R8", 32'(mem_we), 32'(load_n && !en_n));
    if (!load_n && !en_n) begin
      if (!wsel) m_ae = d[OFS_W-1:0]; else m_af = d[OFS_W-1:0];
      wsel = !wsel;
    end
    @(negedge wr_clk);
    wr_en_n = 1;
  endtask

  task automatic do_read(input logic en_n);
    @(negedge rd_clk);
    rd_en_n = en_n;
    #1;
    chk(mem_re == (load_n && !en_n), "R8", 32'(mem_re), 32'(load_n && !en_n));
    if (!load_n && !en_n) begin
      exp_q.push_back(DATA_W'(rsel ? m_af : m_ae));
      rsel = !rsel;
    end
    @(negedge rd_clk);
    rd_en_n = 1;
  endtask

  // monitor: compares each readback against the queued expectation (R7, R9)
  always @(posedge rd_clk) begin
    if (rst_n && !load_n && !rd_en_n) begin
      @(negedge rd_clk);
      if (exp_q.size() == 0) chk(0, "R7", 32'(rdata), 32'hx);
      else begin
        ex = exp_q.pop_front();
        chk(rdata == ex, "R7", 32'(rdata), 32'(ex));
        chk(rdata[DATA_W-1:OFS_W] == '0, "R9", 32'(rdata), 32'(ex));
      end
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  logic [DATA_W-1:0] hold;

  initial begin
    do_reset();
    // R1: defaults after reset
    chk_ofs("R1");
    chk(rdata == '0, "R1", 32'(rdata), 0);

    // R5: normal traffic leaves offsets alone
    do_write(18'h01234, 0);
    chk_ofs("R5");

    set_load(0);
    // R2 / R3: empty, full, empty; upper data bits dropped
    do_write(18'h2C005, 0); chk_ofs("R2");
    do_write(18'h00321, 0); chk_ofs("R3");
    do_write(18'h3FFFF, 0); chk_ofs("R3");
    // R4: disabled edge with load low
    do_write(18'h00777, 1); chk_ofs("R4");

    // R6: leave programming after odd count, resume
    set_load(1);
    do_write(18'h00055, 1); chk_ofs("R4");
    do_write(18'h00066, 0); chk_ofs("R5");
    set_load(0);
    do_write(18'h00ABC, 0); chk_ofs("R6");

    // R7 / R10: readback in own order, untouched by writes
    do_read(0);
    do_read(0);
    do_write(18'h00042, 0); chk_ofs("R10");
    do_read(0);
    do_read(0);
    repeat (2) @(negedge rd_clk);
    chk(exp_q.size() == 0, "R7", 32'(exp_q.size()), 0);

    // R8: non-readback read edges hold output
    hold = rdata;
    do_read(1);
    chk(rdata == hold, "R8", 32'(rdata), 32'(hold));
    set_load(1);
    do_read(0);
    chk(rdata == hold, "R8", 32'(rdata), 32'(hold));

    // R1: reset in the middle returns defaults and both selectors to empty
    set_load(0);
    do_write(18'h00011, 0);
    do_reset();
    chk_ofs("R1");
    chk(rdata == '0, "R1", 32'(rdata), 0);
    do_write(18'h00099, 0); chk_ofs("R1");
    do_read(0);
    repeat (3) @(negedge rd_clk);
    chk(exp_q.size() == 0, "R1", 32'(exp_q.size()), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule